// File: doc/BRIEF.md
# Halted-Core Exception Filter and Debug Status

This block sits beside the exception logic of a processor core. It decides what each exception event does, depending on whether the core is halted for an external debugger or running normally. While the core runs, undefined-instruction, precise-abort, supervisor-call and secure-monitor-call events each raise a take strobe. A precise abort also records its fault status and faulting address. An imprecise abort is held pending until it can be taken.

While the core is halted, no exception vectors. Call events are dropped. Undefined-instruction and abort events leave a sticky flag in the debug status word for the debugger to inspect, and only a precise abort writes the fault registers. The fault registers come in a secure bank and a non-secure bank, and the current security state picks one. The status word also carries two other fields. The first is the entry-cause field, captured when the core halts. The second is a drain-complete flag that reports when a memory barrier issued from the debugger has finished.

The event inputs are single-cycle pulses with no back-pressure. The block accepts one of each kind in every cycle and never stalls its source. All outputs are plain registered control and status pins.

Top module: `dbg_exc_filter`

## Requirements
- R1: When `halted_i` is low, a pulse on `ev_undef_i`, `ev_pabort_i`, `ev_svc_i` or `ev_smc_i` produces a single-cycle pulse on the matching `take_*_o` output in the cycle after the event.
- R2: When `halted_i` is high, `ev_svc_i` and `ev_smc_i` produce no take strobe and leave `dbg_status_o` and all four fault registers unchanged.
- R3: When `halted_i` is high, `ev_undef_i` produces no take strobe and sets status bit 8 in the next cycle.
- R4: A precise abort loads `pabt_fsr_i` and `pabt_far_i` into one fault bank in the next cycle, whether the core is halted or not. `nonsecure_i` = 0 selects the secure bank (`sec_*_o`) and 1 selects the non-secure bank (`ns_*_o`). When `halted_i` is high, the abort also sets status bit 6 and produces no take strobe.
- R5: When `halted_i` is high, `ev_iabort_i` sets status bit 7 and leaves the fault registers unchanged, whatever `cpsr_a_i` is. The abort is not left pending.
- R6: When `halted_i` is low, an imprecise abort becomes pending. `take_iabort_o` pulses once, in the cycle after the first edge at which the abort is pending (or arriving), `cpsr_a_i` is low and `halted_i` is low. Taking the abort clears the pending state.
- R7: Status bits 5:2 capture `entry_cause_i` at the clock edge where `halted_i` first goes high. No other input changes them while the core stays halted.
- R8: Status bit 19 is cleared at the edge where the core enters the halted state. It is set at the first later edge at which a drain is in progress (a `drain_req_i` pulse seen in that cycle or earlier) and `mem_idle_i` is high. It then stays set until the next entry.
- R9: `sticky_clr_i` is write-one-to-clear: bit 0 clears status bit 6, bit 1 clears bit 7 and bit 2 clears bit 8. Leaving the halted state clears no sticky bit.
- R10: When an event and the clear for the same sticky bit arrive in the same cycle, the sticky bit ends up set.
- R11: After reset, all take strobes, `dbg_status_o` and all fault registers are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| halted_i | input | 1 | Core is in the halted debug state |
| cpsr_a_i | input | 1 | Imprecise-abort mask bit of the program status |
| nonsecure_i | input | 1 | Current security state, 1 = non-secure |
| entry_cause_i | input | 4 | Reason for the halt, captured on entry |
| ev_undef_i | input | 1 | Undefined-instruction event pulse |
| ev_pabort_i | input | 1 | Precise data abort event pulse |
| pabt_fsr_i | input | FSR_W | Fault status of the precise abort |
| pabt_far_i | input | ADDR_W | Faulting address of the precise abort |
| ev_iabort_i | input | 1 | Imprecise data abort event pulse |
| ev_svc_i | input | 1 | Supervisor call event pulse |
| ev_smc_i | input | 1 | Secure monitor call event pulse |
| sticky_clr_i | input | 3 | Write-one-to-clear for sticky bits 6, 7, 8 |
| drain_req_i | input | 1 | Barrier drain request pulse |
| mem_idle_i | input | 1 | No memory operations outstanding |
| take_undef_o | output | 1 | Take undefined-instruction exception |
| take_pabort_o | output | 1 | Take precise abort |
| take_iabort_o | output | 1 | Take imprecise abort |
| take_svc_o | output | 1 | Take supervisor call |
| take_smc_o | output | 1 | Take secure monitor call |
| dbg_status_o | output | 32 | Debug status word |
| sec_fsr_o | output | FSR_W | Secure fault status |
| sec_far_o | output | ADDR_W | Secure fault address |
| ns_fsr_o | output | FSR_W | Non-secure fault status |
| ns_far_o | output | ADDR_W | Non-secure fault address |

## Verification
Every result of this block appears exactly one clock edge after the inputs that cause it. This holds for take strobes, sticky bits, fault banks, the entry-cause field and the drain flag. The only exceptions are a pending imprecise abort and a drain waiting on memory, which resolve one edge after their gating condition becomes true. The bench drives inputs on the falling edge and samples all outputs on the next falling edge, which is one rising edge later. Each event therefore sits in its own vector, and any stimulus whose effect is deferred, such as a masked imprecise abort or a drain request, is followed by idle vectors whose expected outputs carry the deferred result.

// File: rtl/dbg_exc_pkg.sv
package dbg_exc_pkg;
  localparam int STAT_W    = 32;
  localparam int MOE_W     = 4;
  localparam int MOE_LO    = 2;
  localparam int MOE_HI    = MOE_LO + MOE_W - 1;
  localparam int BIT_PABT  = 6;
  localparam int BIT_IABT  = 7;
  localparam int BIT_UND   = 8;
  localparam int BIT_DRAIN = 19;
  localparam int N_STICKY  = 3;

  // index of each sticky flag inside the sticky vector (and clear vector)
  typedef enum int {STK_PABT = 0, STK_IABT = 1, STK_UND = 2} sticky_idx_e;

  typedef enum logic {BANK_SEC = 1'b0, BANK_NS = 1'b1} fault_bank_e;
endpackage

// File: rtl/dbg_sticky_flags.sv
module dbg_sticky_flags #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] flags_o
);
  for (genvar g = 0; g < N; g++) begin : g_flag
    logic flag_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        flag_q <= 1'b0;
      else if (set_i[g]) flag_q <= 1'b1;   // event beats clear
      else if (clr_i[g]) flag_q <= 1'b0;
    end
    assign flags_o[g] = flag_q;

    assert_set_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
      set_i[g] |=> flags_o[g]);
    assert_clear_only_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i[g] && !set_i[g]) |=> !flags_o[g]);
    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr_i[g] && !set_i[g]) |=> $stable(flags_o[g]));
  end
endmodule

// File: rtl/dbg_fault_bank.sv
module dbg_fault_bank #(
  parameter int FSR_W  = 8,
  parameter int ADDR_W = 32,
  parameter int BANKS  = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        we_i,
  input  logic [SEL_W-1:0]            sel_i,
  input  logic [FSR_W-1:0]            fsr_i,
  input  logic [ADDR_W-1:0]           far_i,
  output logic [BANKS-1:0][FSR_W-1:0]  fsr_o,
  output logic [BANKS-1:0][ADDR_W-1:0] far_o
);
  localparam int SEL_W = (BANKS > 1) ? $clog2(BANKS) : 1;

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    logic hit;
    assign hit = we_i && (sel_i == SEL_W'(b));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        fsr_o[b] <= '0;
        far_o[b] <= '0;
      end else if (hit) begin
        fsr_o[b] <= fsr_i;
        far_o[b] <= far_i;
      end
    end

    assert_bank_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !we_i |=> ($stable(fsr_o[b]) && $stable(far_o[b])));
  end
endmodule

// File: rtl/dbg_entry_track.sv
module dbg_entry_track #(
  parameter int MOE_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             halted_i,
  input  logic [MOE_W-1:0] cause_i,
  input  logic             drain_req_i,
  input  logic             mem_idle_i,
  output logic [MOE_W-1:0] moe_o,
  output logic             drain_done_o
);
  logic halted_q, draining_q, entry, drain_live;

  assign entry      = halted_i && !halted_q;
  assign drain_live = draining_q || drain_req_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      halted_q     <= 1'b0;
      draining_q   <= 1'b0;
      moe_o        <= '0;
      drain_done_o <= 1'b0;
    end else begin
      halted_q <= halted_i;
      if (entry) begin
        moe_o        <= cause_i;
        drain_done_o <= 1'b0;
        draining_q   <= 1'b0;
      end else if (drain_live && mem_idle_i) begin
        drain_done_o <= 1'b1;
        draining_q   <= 1'b0;
      end else if (drain_req_i) begin
        draining_q   <= 1'b1;
      end
    end
  end

  assert_entry_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    entry |=> !drain_done_o);
  assert_done_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (drain_done_o && !entry) |=> drain_done_o);
  assert_moe_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (halted_i && halted_q) |=> $stable(moe_o));
endmodule

// File: rtl/dbg_exc_filter.sv
module dbg_exc_filter
  import dbg_exc_pkg::*;
#(
  parameter int FSR_W  = 8,
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              halted_i,
  input  logic              cpsr_a_i,
  input  logic              nonsecure_i,
  input  logic [3:0]        entry_cause_i,
  input  logic              ev_undef_i,
  input  logic              ev_pabort_i,
  input  logic [FSR_W-1:0]  pabt_fsr_i,
  input  logic [ADDR_W-1:0] pabt_far_i,
  input  logic              ev_iabort_i,
  input  logic              ev_svc_i,
  input  logic              ev_smc_i,
  input  logic [2:0]        sticky_clr_i,
  input  logic              drain_req_i,
  input  logic              mem_idle_i,
  output logic              take_undef_o,
  output logic              take_pabort_o,
  output logic              take_iabort_o,
  output logic              take_svc_o,
  output logic              take_smc_o,
  output logic [31:0]       dbg_status_o,
  output logic [FSR_W-1:0]  sec_fsr_o,
  output logic [ADDR_W-1:0] sec_far_o,
  output logic [FSR_W-1:0]  ns_fsr_o,
  output logic [ADDR_W-1:0] ns_far_o
);
  localparam int BANKS = 2;

  // ---------------- imprecise abort pending and take gating
  logic iabt_pend_q, iabt_pend_in, iabt_take;
  assign iabt_pend_in = iabt_pend_q || (ev_iabort_i && !halted_i);
  assign iabt_take    = iabt_pend_in && !cpsr_a_i && !halted_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      iabt_pend_q   <= 1'b0;
      take_undef_o  <= 1'b0;
      take_pabort_o <= 1'b0;
      take_iabort_o <= 1'b0;
      take_svc_o    <= 1'b0;
      take_smc_o    <= 1'b0;
    end else begin
      iabt_pend_q   <= iabt_pend_in && !iabt_take;
      take_undef_o  <= ev_undef_i  && !halted_i;
      take_pabort_o <= ev_pabort_i && !halted_i;
      take_iabort_o <= iabt_take;
      take_svc_o    <= ev_svc_i    && !halted_i;
      take_smc_o    <= ev_smc_i    && !halted_i;
    end
  end

  // ---------------- sticky flags, set only while halted
  logic [N_STICKY-1:0] stk_set, stk_flags;
  always_comb begin
    stk_set          = '0;
    stk_set[STK_PABT] = halted_i && ev_pabort_i;
    stk_set[STK_IABT] = halted_i && ev_iabort_i;
    stk_set[STK_UND]  = halted_i && ev_undef_i;
  end

  dbg_sticky_flags #(.N(N_STICKY)) u_sticky (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_i   (stk_set),
    .clr_i   (sticky_clr_i),
    .flags_o (stk_flags)
  );

  // ---------------- banked fault registers
  logic [BANKS-1:0][FSR_W-1:0]  bank_fsr;
  logic [BANKS-1:0][ADDR_W-1:0] bank_far;
  fault_bank_e bank_sel;
  assign bank_sel = nonsecure_i ? BANK_NS : BANK_SEC;

  dbg_fault_bank #(.FSR_W(FSR_W), .ADDR_W(ADDR_W), .BANKS(BANKS)) u_bank (
    .clk   (clk),
    .rst_n (rst_n),
    .we_i  (ev_pabort_i),
    .sel_i (bank_sel),
    .fsr_i (pabt_fsr_i),
    .far_i (pabt_far_i),
    .fsr_o (bank_fsr),
    .far_o (bank_far)
  );

  assign sec_fsr_o = bank_fsr[BANK_SEC];
  assign sec_far_o = bank_far[BANK_SEC];
  assign ns_fsr_o  = bank_fsr[BANK_NS];
  assign ns_far_o  = bank_far[BANK_NS];

  // ---------------- entry cause and barrier drain
  logic [MOE_W-1:0] moe;
  logic             drain_done;

  dbg_entry_track #(.MOE_W(MOE_W)) u_entry (
    .clk          (clk),
    .rst_n        (rst_n),
    .halted_i     (halted_i),
    .cause_i      (entry_cause_i),
    .drain_req_i  (drain_req_i),
    .mem_idle_i   (mem_idle_i),
    .moe_o        (moe),
    .drain_done_o (drain_done)
  );

  // ---------------- status word
  always_comb begin
    dbg_status_o                = '0;
    dbg_status_o[MOE_HI:MOE_LO] = moe;
    dbg_status_o[BIT_PABT]      = stk_flags[STK_PABT];
    dbg_status_o[BIT_IABT]      = stk_flags[STK_IABT];
    dbg_status_o[BIT_UND]       = stk_flags[STK_UND];
    dbg_status_o[BIT_DRAIN]     = drain_done;
  end

  // ---------------- assertions
  assert_strobe_svc_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!halted_i && ev_svc_i) |=> take_svc_o);
  assert_strobe_undef_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!halted_i && ev_undef_i) |=> take_undef_o);
  assert_no_take_halted_R2: assert property (@(posedge clk) disable iff (!rst_n)
    halted_i |=> !(take_undef_o || take_pabort_o || take_iabort_o || take_svc_o || take_smc_o));
  assert_undef_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (halted_i && ev_undef_i) |=> dbg_status_o[BIT_UND]);
  assert_pabt_sec_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_pabort_i && !nonsecure_i) |=> (sec_fsr_o == $past(pabt_fsr_i) && sec_far_o == $past(pabt_far_i)));
  assert_pabt_ns_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_pabort_i && nonsecure_i) |=> (ns_fsr_o == $past(pabt_fsr_i) && ns_far_o == $past(pabt_far_i)));
  assert_iabt_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (halted_i && ev_iabort_i) |=> dbg_status_o[BIT_IABT]);
  assert_iabt_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    take_iabort_o |-> ($past(!cpsr_a_i) && $past(!halted_i)));
  assert_iabt_once_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (take_iabort_o && !ev_iabort_i) |=> !take_iabort_o);
endmodule

// File: tb/dbg_exc_filter_bench.sv
module dbg_exc_filter_bench;
  localparam int FSR_W  = 8;
  localparam int ADDR_W = 32;
  localparam int NVEC   = 24;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              halted_i = 1'b0, cpsr_a_i = 1'b0, nonsecure_i = 1'b0;
  logic [3:0]        entry_cause_i = '0;
  logic              ev_undef_i = 1'b0, ev_pabort_i = 1'b0, ev_iabort_i = 1'b0;
  logic              ev_svc_i = 1'b0, ev_smc_i = 1'b0;
  logic [FSR_W-1:0]  pabt_fsr_i = '0;
  logic [ADDR_W-1:0] pabt_far_i = '0;
  logic [2:0]        sticky_clr_i = '0;
  logic              drain_req_i = 1'b0, mem_idle_i = 1'b0;
  logic              take_undef_o, take_pabort_o, take_iabort_o, take_svc_o, take_smc_o;
  logic [31:0]       dbg_status_o;
  logic [FSR_W-1:0]  sec_fsr_o, ns_fsr_o;
  logic [ADDR_W-1:0] sec_far_o, ns_far_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;   // 250 MHz

  dbg_exc_filter #(.FSR_W(FSR_W), .ADDR_W(ADDR_W)) u_dbg_exc_filter (
    .clk(clk), .rst_n(rst_n), .halted_i(halted_i), .cpsr_a_i(cpsr_a_i),
    .nonsecure_i(nonsecure_i), .entry_cause_i(entry_cause_i),
    .ev_undef_i(ev_undef_i), .ev_pabort_i(ev_pabort_i), .pabt_fsr_i(pabt_fsr_i),
    .pabt_far_i(pabt_far_i), .ev_iabort_i(ev_iabort_i), .ev_svc_i(ev_svc_i),
    .ev_smc_i(ev_smc_i), .sticky_clr_i(sticky_clr_i), .drain_req_i(drain_req_i),
    .mem_idle_i(mem_idle_i), .take_undef_o(take_undef_o), .take_pabort_o(take_pabort_o),
    .take_iabort_o(take_iabort_o), .take_svc_o(take_svc_o), .take_smc_o(take_smc_o),
    .dbg_status_o(dbg_status_o), .sec_fsr_o(sec_fsr_o), .sec_far_o(sec_far_o),
    .ns_fsr_o(ns_fsr_o), .ns_far_o(ns_far_o)
  );

  // vector: halted,a,ns | undef,pab,iab,svc,smc | clr[2:0] | take undef,pab,iab,svc,smc | sticky b8,b7,b6
  localparam logic [18:0] VEC [0:NVEC-1] = '{
    19'b0_0_0_00000_000_00000_000,  // idle
    19'b0_0_0_10000_000_10000_000,  // R1 undef taken
    19'b0_0_0_01000_000_01000_000,  // R1 precise abort taken
    19'b0_0_0_00010_000_00010_000,  // R1 svc taken
    19'b0_0_0_00001_000_00001_000,  // R1 smc taken
    19'b0_0_0_00100_000_00100_000,  // R6 imprecise taken at once
    19'b0_1_0_00100_000_00000_000,  // R6 masked: pending
    19'b0_1_0_00000_000_00000_000,  // R6 still masked
    19'b0_0_0_00000_000_00100_000,  // R6 unmasked: taken
    19'b0_0_0_00000_000_00000_000,  // R6 only once
    19'b0_1_0_00100_000_00000_000,  // R6 pending again
    19'b1_0_0_00000_000_00000_000,  // R6 halted gates pending
    19'b1_0_0_00011_000_00000_000,  // R2 svc/smc ignored
    19'b1_0_0_10000_000_00000_100,  // R3 undef sticky
    19'b1_0_1_01000_000_00000_101,  // R4 precise sticky
    19'b1_1_0_00100_000_00000_111,  // R5 imprecise sticky with A set
    19'b1_0_0_00000_001_00000_110,  // R9 clear bit 6
    19'b1_0_0_10000_100_00000_110,  // R10 event beats clear
    19'b1_0_0_00000_010_00000_100,  // R9 clear bit 7
    19'b0_0_0_00000_000_00100_100,  // R6 pending taken on exit, R9 stays set
    19'b0_0_0_00000_100_00000_000,  // R9 clear bit 8
    19'b1_0_0_00100_000_00000_010,  // R5 halted imprecise not pending
    19'b0_0_0_00000_000_00000_010,  // R5 no take on exit
    19'b0_0_0_00000_111_00000_000   // R9 clear all
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle_events();
    ev_undef_i = 0; ev_pabort_i = 0; ev_iabort_i = 0; ev_svc_i = 0; ev_smc_i = 0;
    sticky_clr_i = '0; drain_req_i = 0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; halted_i = 0; cpsr_a_i = 0; nonsecure_i = 0; mem_idle_i = 0;
    idle_events();
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
  endtask

  function automatic logic [2:0] stk();
    return {dbg_status_o[8], dbg_status_o[7], dbg_status_o[6]};
  endfunction

  initial begin
    logic [31:0] st_before;
    do_reset();
    // R11 reset state
    chk("R11 status", 64'(dbg_status_o), 64'h0);
    chk("R11 takes", 64'({take_undef_o, take_pabort_o, take_iabort_o, take_svc_o, take_smc_o}), 64'h0);
    chk("R11 fault regs", 64'({sec_fsr_o, ns_fsr_o} | sec_far_o | ns_far_o), 64'h0);

    // table walk
    for (int i = 0; i < NVEC; i++) begin
      halted_i = VEC[i][18]; cpsr_a_i = VEC[i][17]; nonsecure_i = VEC[i][16];
      ev_undef_i = VEC[i][15]; ev_pabort_i = VEC[i][14]; ev_iabort_i = VEC[i][13];
      ev_svc_i = VEC[i][12]; ev_smc_i = VEC[i][11]; sticky_clr_i = VEC[i][10:8];
      @(negedge clk);
      chk($sformatf("R1 R2 R6 take vec%0d", i),
          64'({take_undef_o, take_pabort_o, take_iabort_o, take_svc_o, take_smc_o}),
          64'(VEC[i][7:3]));
      chk($sformatf("R3 R4 R5 R9 R10 sticky vec%0d", i), 64'(stk()), 64'(VEC[i][2:0]));
    end
    idle_events(); halted_i = 0; cpsr_a_i = 0;

    // directed: banks, entry cause, drain
    do_reset();
    pabt_fsr_i = 8'h15; pabt_far_i = 32'h1000_0040; nonsecure_i = 0; ev_pabort_i = 1;
    @(negedge clk); ev_pabort_i = 0;
    chk("R4 secure fsr", 64'(sec_fsr_o), 64'h15);
    chk("R4 secure far", 64'(sec_far_o), 64'h1000_0040);
    chk("R4 ns bank untouched", 64'(ns_far_o), 64'h0);

    entry_cause_i = 4'b0101; halted_i = 1;
    @(negedge clk);
    chk("R7 entry cause captured", 64'(dbg_status_o[5:2]), 64'h5);
    chk("R8 drain cleared on entry", 64'(dbg_status_o[19]), 64'h0);

    pabt_fsr_i = 8'h2A; pabt_far_i = 32'hDEAD_0000; nonsecure_i = 1; ev_pabort_i = 1;
    @(negedge clk); ev_pabort_i = 0;
    chk("R4 ns fsr in debug", 64'(ns_fsr_o), 64'h2A);
    chk("R4 ns far in debug", 64'(ns_far_o), 64'hDEAD_0000);
    chk("R4 secure kept", 64'(sec_far_o), 64'h1000_0040);
    chk("R4 take suppressed", 64'(take_pabort_o), 64'h0);

    // R5 imprecise in debug leaves fault registers
    pabt_fsr_i = 8'h77; pabt_far_i = 32'h0BAD_0BAD; ev_iabort_i = 1;
    @(negedge clk); ev_iabort_i = 0;
    chk("R5 ns fsr unchanged", 64'(ns_fsr_o), 64'h2A);
    chk("R5 secure far unchanged", 64'(sec_far_o), 64'h1000_0040);

    // R2 svc/smc change nothing; R7 cause change ignored while halted
    st_before = dbg_status_o;
    entry_cause_i = 4'b1010; ev_svc_i = 1; ev_smc_i = 1;
    @(negedge clk); ev_svc_i = 0; ev_smc_i = 0;
    chk("R2 status unchanged", 64'(dbg_status_o), 64'(st_before));
    chk("R2 fault unchanged", 64'(ns_fsr_o), 64'h2A);
    ev_undef_i = 1;
    @(negedge clk); ev_undef_i = 0;
    chk("R7 cause held while halted", 64'(dbg_status_o[5:2]), 64'h5);

    // R8 drain
    mem_idle_i = 0; drain_req_i = 1;
    @(negedge clk); drain_req_i = 0;
    @(negedge clk); @(negedge clk);
    chk("R8 drain busy", 64'(dbg_status_o[19]), 64'h0);
    mem_idle_i = 1;
    @(negedge clk);
    chk("R8 drain done", 64'(dbg_status_o[19]), 64'h1);
    halted_i = 0;
    @(negedge clk);
    chk("R8 done held after exit", 64'(dbg_status_o[19]), 64'h1);
    chk("R9 sticky kept after exit", 64'(stk()), 64'b111);
    entry_cause_i = 4'b0011; halted_i = 1;
    @(negedge clk);
    chk("R8 re-entry clears", 64'(dbg_status_o[19]), 64'h0);
    chk("R7 new cause", 64'(dbg_status_o[5:2]), 64'h3);
    mem_idle_i = 1; drain_req_i = 1;
    @(negedge clk); drain_req_i = 0;
    chk("R8 same-cycle drain", 64'(dbg_status_o[19]), 64'h1);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(4 * 20000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule